// File: doc/BRIEF.md
# Periodic Down-Count Interval Timer

This block is a programmable 16-bit interval timer that counts down by one on each fixed time tick. An internal prescaler divides the system clock by `CLKS_PER_TICK` to make the tick, so one tick lasts 100 microseconds at the intended clock rate. Software sets a preload value and an enable bit through a small word-addressed register port. Setting the enable bit loads the count from the preload value. After the count passes 0000h the next tick takes it to FFFFh, and the count does not return to the preload value. Each such wrap sets a sticky status bit, which software clears by writing a one.

A level interrupt output is high while the status bit and the interrupt-enable bit are both set. A preload write made while the timer runs restarts the count from the new value at once. Clearing the enable bit freezes the count and returns the preload field to FFFFh. Software can read the live count at any time, and reading has no side effect.

Register map (word address on `bus_addr`): 0 = configuration, with the preload in bits [15:0] and the enable in bit 16. 1 = live count, read-only, in bits [15:0]. 2 = wrap status in bit 0, cleared by writing 1. 3 = interrupt enable in bit 0. Unused bits read as zero.

Top module: `tmr_interval_top`

## Requirements
- R1: After reset the count reads FFFFh, the configuration reads 0000FFFFh (preload FFFFh, enable 0), the status reads 0, `irq` is 0 and `bus_rdata` is 0.
- R2: A write to address 0 with bit 16 = 1 loads the count with bits [15:0] of that write. This holds both when the timer is being enabled and when it is already running.
- R3: While the timer is enabled, the count drops by one every `CLKS_PER_TICK` clock cycles. The first drop comes exactly `CLKS_PER_TICK` cycles after the load, because every load restarts the prescaler.
- R4: A tick that finds the count at 0000h sets it to FFFFh, not to the preload value, and counting continues downward from FFFFh.
- R5: The tick that takes the count from 0000h to FFFFh sets the status bit (address 2, bit 0) on the same clock edge.
- R6: The status bit stays set until a write to address 2 with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged.
- R7: If a wrap and a write-1 clear of the status bit fall on the same clock edge, the status bit ends up set.
- R8: `irq` is 1 exactly when the status bit and the interrupt-enable bit (address 3, bit 0) are both 1. It changes on the same edge as those bits.
- R9: A write to address 0 with bit 16 = 0 while the timer is enabled sets the preload field to FFFFh, whatever the write data. After that the count holds its value.
- R10: A write to address 0 with bit 16 = 0 while the timer is disabled stores bits [15:0] as the preload and leaves the count unchanged.
- R11: Writes to address 1 have no effect on the count, and reading the count does not change it.
- R12: `bus_rdata` takes the addressed register's value on the edge where `bus_rd` is high, and holds it while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, captures read data on the next edge |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, status AND interrupt enable |

## Verification
A prescaler phase that is out of step after a load shows up as a count that is one off. A read taken `CLKS_PER_TICK` cycles after the load reveals it, so the bench reads exactly on both sides of the first decrement edge. A wrong value at the wrap is visible in the first read after the zero-crossing tick: the count returns the preload instead of FFFFh, or the status bit stays clear. A lost set or a lost clear reaches `irq` on the same edge. The directed scenarios place the status clear on the wrap edge itself, and they sample `irq` one cycle before and on the wrap edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    A_CFG   = 2'd0,
    A_COUNT = 2'd1,
    A_STAT  = 2'd2,
    A_IEN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CLKS_PER_TICK = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase_q <= '0;
    else if (phase_q == LAST)   phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign tick_o = run && !restart && (phase_q == LAST);

  // R3: phase never leaves the divide range
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST);

  // R3: a restart makes the next tick a full period away
  p_restart_clears_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '1;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;
  assign wrap_o  = tick && !load && (count_q == '0);

  // R2: load takes priority and lands on the next edge
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(load_val)));

  // R3: one step down per tick above zero
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (count_q != '0)) |=> (count_q == CNT_W'($past(count_q) - 1'b1)));

  // R4: zero crossing wraps to all ones
  p_wrap_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (count_q == '0)) |=> (count_q == '1));

  // R9: no tick and no load keeps the count
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(count_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             en_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  localparam int EN_POS = CNT_W;

  logic [CNT_W-1:0] preload_q;
  logic             en_q, sts_q, ie_q, irq_q;
  logic [BUS_W-1:0] rdata_q;
  logic             cfg_wr, stat_clr, ien_wr, new_en;
  logic             sts_d, ie_d;
  logic             unused_wbits;

  assign cfg_wr   = wr && (addr == A_CFG);
  assign stat_clr = wr && (addr == A_STAT) && wdata[0];
  assign ien_wr   = wr && (addr == A_IEN);
  assign new_en   = wdata[EN_POS];
  assign unused_wbits = ^wdata[BUS_W-1:EN_POS+1];

  assign sts_d = wrap_i || (sts_q && !stat_clr);
  assign ie_d  = ien_wr ? wdata[0] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= '1;
      en_q      <= 1'b0;
      sts_q     <= 1'b0;
      ie_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cfg_wr) begin
        en_q      <= new_en;
        preload_q <= (en_q && !new_en) ? '1 : wdata[CNT_W-1:0];
      end
      sts_q <= sts_d;
      ie_q  <= ie_d;
      irq_q <= sts_d && ie_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      case (addr)
        A_CFG:   rdata_q <= BUS_W'({en_q, preload_q});
        A_COUNT: rdata_q <= BUS_W'(count_i);
        A_STAT:  rdata_q <= BUS_W'(sts_q);
        default: rdata_q <= BUS_W'(ie_q);
      endcase
    end
  end

  assign rdata_o    = rdata_q;
  assign irq_o      = irq_q;
  assign en_o       = en_q;
  assign load_o     = cfg_wr && new_en;
  assign load_val_o = wdata[CNT_W-1:0];

  // R5: a wrap always leaves status set
  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> sts_q);

  // R7: set beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && stat_clr) |=> sts_q);

  // R6: status only falls on a write of one
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !stat_clr) |=> sts_q);

  // R8: interrupt line tracks status and enable
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (sts_q && ie_q));

  // R9: disabling a running timer restores preload to all ones
  p_disable_preload_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && en_q && !new_en) |=> (preload_q == '1));

  // R12: read data holds without a strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q));
endmodule

// File: rtl/tmr_interval_top.sv
module tmr_interval_top
  import tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int CLKS_PER_TICK = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  logic             en, load, tick, wrap;
  logic [CNT_W-1:0] load_val, count;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count_i(count), .wrap_i(wrap), .rdata_o(bus_rdata),
    .irq_o(irq), .en_o(en), .load_o(load), .load_val_o(load_val)
  );

  tmr_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
    .clk(clk), .rst(rst), .run(en), .restart(load), .tick_o(tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick),
    .count_o(count), .wrap_o(wrap)
  );
endmodule

// File: tb/tmr_interval_top_tb.sv
module tmr_interval_top_tb;
  localparam int N = 4;
  localparam logic [1:0] CFG = 2'd0, CNT = 2'd1, STS = 2'd2, IEN = 2'd3;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr_interval_top #(.CNT_W(16), .CLKS_PER_TICK(N)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic prep();
    bwr(CFG, 32'h0);
    bwr(STS, 32'h1);
  endtask

  task automatic load(input logic [15:0] v);
    bwr(CFG, {15'd0, 1'b1, v});
  endtask

  task automatic t_reset();
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    brd(CNT, rv); chk("R1 count", rv, 32'h0000_FFFF);
    brd(CFG, rv); chk("R1 cfg", rv, 32'h0000_FFFF);
    brd(STS, rv); chk("R1 status", rv, 32'h0);
  endtask

  task automatic t_count_timing();
    prep(); load(16'h1234); idle(N-1);
    brd(CNT, rv); chk("R3 before first tick", rv, 32'h1234);
    prep(); load(16'h1234); idle(N);
    brd(CNT, rv); chk("R3 first tick", rv, 32'h1233);
    prep(); load(16'h0010); idle(5*N);
    brd(CNT, rv); chk("R3 five ticks", rv, 32'h000B);
  endtask

  task automatic t_wrap();
    prep(); load(16'h0001); idle(2*N-1);
    brd(STS, rv); chk("R5 status before wrap", rv, 32'h0);
    brd(CNT, rv); chk("R4 wrap to ones", rv, 32'h0000_FFFF);
    brd(STS, rv); chk("R5 status after wrap", rv, 32'h1);
    idle(2);
    brd(CNT, rv); chk("R4 keeps counting", rv, 32'h0000_FFFE);
  endtask

  task automatic t_sticky_and_race();
    prep(); load(16'h0000); idle(N-1);
    bwr(STS, 32'h1);                       // lands on the wrap edge
    brd(STS, rv); chk("R7 set wins", rv, 32'h1);
    bwr(STS, 32'h0);
    brd(STS, rv); chk("R6 write zero", rv, 32'h1);
    bwr(STS, 32'h1);
    brd(STS, rv); chk("R6 write one clears", rv, 32'h0);
  endtask

  task automatic t_irq();
    prep(); bwr(IEN, 32'h1);
    brd(IEN, rv); chk("R12 ien readback", rv, 32'h1);
    load(16'h0000); idle(N-1);
    chk("R8 irq before wrap", {31'd0, irq}, 32'h0);
    idle(1);
    chk("R8 irq on wrap", {31'd0, irq}, 32'h1);
    bwr(IEN, 32'h0); chk("R8 irq masked", {31'd0, irq}, 32'h0);
    bwr(IEN, 32'h1); chk("R8 irq unmasked", {31'd0, irq}, 32'h1);
    bwr(STS, 32'h1); chk("R8 irq cleared", {31'd0, irq}, 32'h0);
    bwr(IEN, 32'h0);
  endtask

  task automatic t_disable_and_preload();
    prep(); load(16'h0100);
    bwr(CFG, 32'h0000_1234);
    brd(CFG, rv); chk("R9 preload to ones", rv, 32'h0000_FFFF);
    idle(20);
    brd(CNT, rv); chk("R9 count holds", rv, 32'h0100);
    bwr(CFG, 32'h0000_0042);
    brd(CFG, rv); chk("R10 preload stored", rv, 32'h0000_0042);
    brd(CNT, rv); chk("R10 count unchanged", rv, 32'h0100);
    bwr(CFG, 32'h0001_0042);
    brd(CNT, rv); chk("R2 enable loads", rv, 32'h0042);
  endtask

  task automatic t_reload_running();
    prep(); load(16'h0050); idle(N+2);
    load(16'h0020); idle(N-1);
    brd(CNT, rv); chk("R2 reload while running", rv, 32'h0020);
    brd(CNT, rv); chk("R3 prescaler restarted", rv, 32'h001F);
  endtask

  task automatic t_readonly_and_hold();
    prep(); load(16'h0300); bwr(CFG, 32'h0);
    bwr(CNT, 32'h0000_0005);
    brd(CNT, rv); chk("R11 count write ignored", rv, 32'h0300);
    brd(CNT, rv); chk("R11 read no side effect", rv, 32'h0300);
    load(16'h0010);
    brd(CNT, rv); chk("R12 read value", rv, 32'h0010);
    idle(3*N);
    chk("R12 rdata holds", bus_rdata, 32'h0010);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_count_timing();
    t_wrap();
    t_sticky_and_race();
    t_irq();
    t_disable_and_preload();
    t_reload_running();
    t_readonly_and_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule